// File: doc/BRIEF.md
# CAN Message Object Acceptance Store

This block is a small associative store of CAN message objects. Each object holds an identifier of up to 29 bits, a flag that marks it as an extended-format object, a direction bit, a data length, eight data bytes, and a handful of control and status bits. The shift register presents each received frame in parallel: identifier, format flag, remote flag, length code and all eight data bytes. In one clock the block compares the identifier against every object at once, using a global acceptance mask. It then writes the payload into the lowest-numbered receive object that matches and flags that object as holding fresh data.

A remote frame does not deliver data. It raises the transmit request of every matching transmit object. A combinational scan always shows the lowest-numbered valid object with a pending transmit request, and exposes that object's identifier, format, length and data in parallel to the transmit side. When the transmit side pulses an acknowledge, the pending request is cleared. A plain word-wide host port reads and writes every object field and the global mask. After this setup, frames are stored and requests are raised and cleared with no host action.

Top module: `can_obj_store`

## Requirements
- R1: After reset every object field reads zero, the global mask reads 0x1FFFFFFF (all bits compared), `rx_hit` and `tx_pend` are low, and `rx_hit_idx` and `tx_idx` are zero.
- R2: A host write with `hst_we` high updates the addressed field at the next clock. `hst_rdata` combinationally returns the addressed field. The field codes are: 0 is control, 1 is identifier in bits [28:0], 2 is length in bits [3:0], 3 is data bytes 0..3 (byte 0 in bits [7:0]), 4 is data bytes 4..7, and 7 is the global mask in bits [28:0]. Field 7 ignores the object index. The control bits are: bit0 valid, bit1 transmit direction, bit2 extended, bit3 transmit request, bit4 new data, bit5 message lost. Unused bits read zero.
- R3: An object matches a frame only when it is valid, its extended bit equals the frame's format flag, and (object id XOR frame id) AND mask is zero. For a standard frame only id bits [10:0] take part.
- R4: A data frame (`rx_rtr`=0) is delivered only to matching receive objects (direction 0), and the lowest-numbered one wins. One clock after `rx_valid`, `rx_hit` pulses for one cycle with `rx_hit_idx` set to the winner. When no object matches, `rx_hit` stays low.
- R5: The winning object stores the length code clamped to 8 and all eight data bytes, and its new-data bit is set.
- R6: If the winner's new-data bit was already set, its message-lost bit is also set. A set message-lost bit is never cleared by a frame.
- R7: A remote frame stores no data and does not raise `rx_hit`. It sets the transmit request of every matching transmit object (direction 1).
- R8: `tx_pend` is high when some valid object has its transmit request set. `tx_idx` is then the lowest such index, and `tx_id`, `tx_ext`, `tx_dlc` and `tx_data` show that object's fields. When nothing is pending, `tx_idx` and these outputs are zero.
- R9: `tx_ack` clears the transmit request of the object reported by `tx_idx` at the next clock, and the scan moves to the next pending object.
- R10: In a cycle with several actions, the host write is applied first, then the acknowledge clear, then the frame update. Matching uses the state from before the clock. A frame therefore overrides the host's length, data and new-data values for the winner. Message-lost is ORed with the pre-clock new-data bit. A remote set beats an acknowledge clear of the same object.
- R11: Host accesses to an object index of 15 or more, in any field other than the mask, are ignored on writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write strobe |
| hst_obj | input | 4 | Host object index |
| hst_field | input | 3 | Host field code |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational) |
| rx_valid | input | 1 | Received frame presented this cycle |
| rx_id | input | 29 | Received identifier (standard in bits [10:0]) |
| rx_ext | input | 1 | Received frame uses the extended format |
| rx_rtr | input | 1 | Received frame is a remote frame |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes, byte 0 in bits [7:0] |
| rx_hit | output | 1 | A data frame was stored last cycle |
| rx_hit_idx | output | 4 | Index of the object that stored it |
| tx_ack | input | 1 | Transmit side consumed the reported object |
| tx_pend | output | 1 | A transmit request is pending |
| tx_idx | output | 4 | Lowest pending transmit object |
| tx_id | output | 29 | Identifier of that object |
| tx_ext | output | 1 | Format flag of that object |
| tx_dlc | output | 4 | Length of that object |
| tx_data | output | 64 | Data of that object |

## Verification
A host write and a frame update can hit the same object in the same clock, as can an acknowledge and a remote-frame request set. The bench provokes both. It drives a control or data write into the object a data frame is about to win, in the same cycle. It also acknowledges the pending object while a remote frame re-requests that object. A bench-side model applies the write, then the clear, then the frame, with the match taken from the state before the clock. Field read-back and the transmit scan judge the outcome: new-data and message-lost must come from the frame, the data must be the frame's, and the transmit request must survive.

// File: rtl/can_store_pkg.sv
package can_store_pkg;
    localparam int CAN_ID_W      = 29;
    localparam int CAN_STD_W     = 11;
    localparam int CAN_MAX_BYTES = 8;
    localparam int CAN_DATA_W    = 8 * CAN_MAX_BYTES;
    localparam int HOST_W        = 32;
    localparam int FLD_W         = 3;

    localparam logic [FLD_W-1:0] FLD_CTRL = 3'd0;
    localparam logic [FLD_W-1:0] FLD_ID   = 3'd1;
    localparam logic [FLD_W-1:0] FLD_LEN  = 3'd2;
    localparam logic [FLD_W-1:0] FLD_DLO  = 3'd3;
    localparam logic [FLD_W-1:0] FLD_DHI  = 3'd4;
    localparam logic [FLD_W-1:0] FLD_MASK = 3'd7;

    typedef struct packed {
        logic lost;
        logic fresh;
        logic xreq;
        logic ext;
        logic xmit;
        logic valid;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t                  ctrl;
        logic [CAN_ID_W-1:0]    id;
        logic [3:0]             len;
        logic [CAN_DATA_W-1:0]  data;
    } mobj_t;
endpackage

// File: rtl/can_obj_match.sv
module can_obj_match
    import can_store_pkg::*;
(
    input  logic                obj_valid,
    input  logic                obj_xmit,
    input  logic                obj_ext,
    input  logic [CAN_ID_W-1:0] obj_id,
    input  logic [CAN_ID_W-1:0] acc_mask,
    input  logic [CAN_ID_W-1:0] frm_id,
    input  logic                frm_ext,
    output logic                rx_match,
    output logic                tx_match
);
    localparam logic [CAN_ID_W-1:0] STD_SPAN =
        {{(CAN_ID_W-CAN_STD_W){1'b0}}, {CAN_STD_W{1'b1}}};

    logic [CAN_ID_W-1:0] width_mask;
    logic                id_eq;
    logic                hit;

    always_comb begin
        width_mask = frm_ext ? '1 : STD_SPAN;
        id_eq      = ((obj_id ^ frm_id) & acc_mask & width_mask) == '0;
        hit        = obj_valid && (obj_ext == frm_ext) && id_eq;
        rx_match   = hit && !obj_xmit;
        tx_match   = hit && obj_xmit;
    end
endmodule

// File: rtl/can_low_pick.sv
module can_low_pick #(
    parameter int N  = 15,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/can_obj_store.sv
module can_obj_store
    import can_store_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ + 1) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hst_we,
    input  logic [IDX_W-1:0]      hst_obj,
    input  logic [FLD_W-1:0]      hst_field,
    input  logic [HOST_W-1:0]     hst_wdata,
    output logic [HOST_W-1:0]     hst_rdata,
    input  logic                  rx_valid,
    input  logic [CAN_ID_W-1:0]   rx_id,
    input  logic                  rx_ext,
    input  logic                  rx_rtr,
    input  logic [3:0]            rx_dlc,
    input  logic [CAN_DATA_W-1:0] rx_data,
    output logic                  rx_hit,
    output logic [IDX_W-1:0]      rx_hit_idx,
    input  logic                  tx_ack,
    output logic                  tx_pend,
    output logic [IDX_W-1:0]      tx_idx,
    output logic [CAN_ID_W-1:0]   tx_id,
    output logic                  tx_ext,
    output logic [3:0]            tx_dlc,
    output logic [CAN_DATA_W-1:0] tx_data
);
    localparam int          HALF_W  = CAN_DATA_W / 2;
    localparam logic [3:0]  LEN_MAX = 4'(CAN_MAX_BYTES);

    typedef struct packed {
        mobj_t [NUM_OBJ-1:0]  objs;
        logic [CAN_ID_W-1:0]  mask;
        logic                 hit;
        logic [IDX_W-1:0]     hit_idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_OBJ-1:0] rx_match;
    logic [NUM_OBJ-1:0] tx_match;
    logic [NUM_OBJ-1:0] tx_req;
    logic               rx_any;
    logic [IDX_W-1:0]   rx_win;
    logic               host_obj_ok;

    // Parallel identifier compare, one comparator per object.
    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        can_obj_match u_match (
            .obj_valid (st_q.objs[g].ctrl.valid),
            .obj_xmit  (st_q.objs[g].ctrl.xmit),
            .obj_ext   (st_q.objs[g].ctrl.ext),
            .obj_id    (st_q.objs[g].id),
            .acc_mask  (st_q.mask),
            .frm_id    (rx_id),
            .frm_ext   (rx_ext),
            .rx_match  (rx_match[g]),
            .tx_match  (tx_match[g])
        );
        assign tx_req[g] = st_q.objs[g].ctrl.valid && st_q.objs[g].ctrl.xreq;
    end

    can_low_pick #(.N(NUM_OBJ), .IW(IDX_W)) u_rx_pick (
        .req (rx_match),
        .any (rx_any),
        .idx (rx_win)
    );

    can_low_pick #(.N(NUM_OBJ), .IW(IDX_W)) u_tx_pick (
        .req (tx_req),
        .any (tx_pend),
        .idx (tx_idx)
    );

    assign host_obj_ok = 32'(hst_obj) < NUM_OBJ;

    // Next-state: host write, then acknowledge clear, then frame update.
    always_comb begin
        st_d         = st_q;
        st_d.hit     = 1'b0;
        st_d.hit_idx = '0;

        if (hst_we) begin
            if (hst_field == FLD_MASK) begin
                st_d.mask = hst_wdata[CAN_ID_W-1:0];
            end else if (host_obj_ok) begin
                case (hst_field)
                    FLD_CTRL: st_d.objs[hst_obj].ctrl = ctrl_t'(hst_wdata[CTRL_W-1:0]);
                    FLD_ID:   st_d.objs[hst_obj].id   = hst_wdata[CAN_ID_W-1:0];
                    FLD_LEN:  st_d.objs[hst_obj].len  = hst_wdata[3:0];
                    FLD_DLO:  st_d.objs[hst_obj].data[HALF_W-1:0] = hst_wdata[HALF_W-1:0];
                    FLD_DHI:  st_d.objs[hst_obj].data[CAN_DATA_W-1:HALF_W] = hst_wdata[HALF_W-1:0];
                    default:  ;
                endcase
            end
        end

        if (tx_ack && tx_pend) begin
            st_d.objs[tx_idx].ctrl.xreq = 1'b0;
        end

        if (rx_valid) begin
            if (!rx_rtr) begin
                if (rx_any) begin
                    st_d.objs[rx_win].len  = (rx_dlc > LEN_MAX) ? LEN_MAX : rx_dlc;
                    st_d.objs[rx_win].data = rx_data;
                    st_d.objs[rx_win].ctrl.lost  = st_d.objs[rx_win].ctrl.lost
                                                 | st_q.objs[rx_win].ctrl.fresh;
                    st_d.objs[rx_win].ctrl.fresh = 1'b1;
                    st_d.hit     = 1'b1;
                    st_d.hit_idx = rx_win;
                end
            end else begin
                for (int i = 0; i < NUM_OBJ; i++) begin
                    if (tx_match[i]) begin
                        st_d.objs[i].ctrl.xreq = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Host read mux.
    always_comb begin
        hst_rdata = '0;
        if (hst_field == FLD_MASK) begin
            hst_rdata = HOST_W'(st_q.mask);
        end else if (host_obj_ok) begin
            case (hst_field)
                FLD_CTRL: hst_rdata = HOST_W'(st_q.objs[hst_obj].ctrl);
                FLD_ID:   hst_rdata = HOST_W'(st_q.objs[hst_obj].id);
                FLD_LEN:  hst_rdata = HOST_W'(st_q.objs[hst_obj].len);
                FLD_DLO:  hst_rdata = HOST_W'(st_q.objs[hst_obj].data[HALF_W-1:0]);
                FLD_DHI:  hst_rdata = HOST_W'(st_q.objs[hst_obj].data[CAN_DATA_W-1:HALF_W]);
                default:  hst_rdata = '0;
            endcase
        end
    end

    // Parallel transmit view of the selected object.
    always_comb begin
        tx_id   = '0;
        tx_ext  = 1'b0;
        tx_dlc  = '0;
        tx_data = '0;
        if (tx_pend) begin
            tx_id   = st_q.objs[tx_idx].id;
            tx_ext  = st_q.objs[tx_idx].ctrl.ext;
            tx_dlc  = st_q.objs[tx_idx].len;
            tx_data = st_q.objs[tx_idx].data;
        end
    end

    assign rx_hit     = st_q.hit;
    assign rx_hit_idx = st_q.hit_idx;
endmodule

// File: rtl/can_obj_store_chk.sv
module can_obj_store_chk #(
    parameter int NUM_OBJ = 15,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_rtr,
    input logic             rx_hit,
    input logic [IDX_W-1:0] rx_hit_idx,
    input logic             tx_pend,
    input logic [IDX_W-1:0] tx_idx
);
    // R4: a hit only follows a data frame presented one clock earlier
    a_r4_hit_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |-> $past(rx_valid && !rx_rtr));

    // R4: a reported winner is a real object
    a_r4_hit_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |-> (32'(rx_hit_idx) < NUM_OBJ));

    // R1: the hit index rests at zero between hits
    a_r1_idle_hit_idx: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_hit |-> (rx_hit_idx == '0));

    // R7: a remote frame never reports a delivery
    a_r7_remote_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rtr) |=> !rx_hit);

    // R8: the transmit scan names a real object, or zero when idle
    a_r8_tx_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend |-> (32'(tx_idx) < NUM_OBJ));

    a_r8_tx_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pend |-> (tx_idx == '0));
endmodule

bind can_obj_store can_obj_store_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_rtr     (rx_rtr),
    .rx_hit     (rx_hit),
    .rx_hit_idx (rx_hit_idx),
    .tx_pend    (tx_pend),
    .tx_idx     (tx_idx)
);

// File: tb/can_obj_store_tb.sv
module can_obj_store_tb_top;
    localparam int CLK_P = 10;
    localparam int NOBJ  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we = 1'b0;
    logic [3:0]  hst_obj = '0;
    logic [2:0]  hst_field = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic        rx_rtr = 1'b0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic        rx_hit;
    logic [3:0]  rx_hit_idx;
    logic        tx_ack = 1'b0;
    logic        tx_pend;
    logic [3:0]  tx_idx;
    logic [28:0] tx_id;
    logic        tx_ext;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;

    int nvec = 0;
    int nerr = 0;

    // Expected store contents. ctrl bits: 0 valid,1 xmit,2 ext,3 xreq,4 fresh,5 lost
    logic [5:0]  m_ctrl [NOBJ];
    logic [28:0] m_id   [NOBJ];
    logic [3:0]  m_len  [NOBJ];
    logic [63:0] m_data [NOBJ];
    logic [28:0] m_mask;

    can_obj_store dut_i (
        .clk(clk), .rst_n(rst_n),
        .hst_we(hst_we), .hst_obj(hst_obj), .hst_field(hst_field),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .rx_valid(rx_valid), .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
        .rx_dlc(rx_dlc), .rx_data(rx_data),
        .rx_hit(rx_hit), .rx_hit_idx(rx_hit_idx),
        .tx_ack(tx_ack), .tx_pend(tx_pend), .tx_idx(tx_idx),
        .tx_id(tx_id), .tx_ext(tx_ext), .tx_dlc(tx_dlc), .tx_data(tx_data)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit id_hit(input int o, input logic [28:0] id, input logic ext);
        logic [28:0] w;
        w = ext ? 29'h1FFF_FFFF : 29'h0000_07FF;
        return m_ctrl[o][0] && (m_ctrl[o][2] == ext) && (((m_id[o] ^ id) & m_mask & w) == '0);
    endfunction

    function automatic int pend_idx();
        for (int o = 0; o < NOBJ; o++)
            if (m_ctrl[o][0] && m_ctrl[o][3]) return o;
        return -1;
    endfunction

    task automatic mwr(input int o, input int f, input logic [31:0] v);
        if (f == 7) m_mask = v[28:0];
        else if (o < NOBJ) begin
            case (f)
                0: m_ctrl[o] = v[5:0];
                1: m_id[o]   = v[28:0];
                2: m_len[o]  = v[3:0];
                3: m_data[o][31:0]  = v;
                4: m_data[o][63:32] = v;
                default: ;
            endcase
        end
    endtask

    task automatic idle_inputs();
        hst_we = 1'b0; rx_valid = 1'b0; rx_rtr = 1'b0; tx_ack = 1'b0;
    endtask

    // One clock carrying any mix of frame, host write and acknowledge.
    task automatic cycle(input logic f_en, input logic [28:0] f_id, input logic f_ext,
                         input logic f_rtr, input logic [3:0] f_dlc, input logic [63:0] f_data,
                         input logic w_en, input int w_o, input int w_f, input logic [31:0] w_v,
                         input logic a_en);
        int win;
        int pi;
        logic pre_fresh;
        logic [NOBJ-1:0] tset;
        win = -1; tset = '0; pre_fresh = 1'b0;
        for (int o = NOBJ - 1; o >= 0; o--) begin
            if (id_hit(o, f_id, f_ext) && !m_ctrl[o][1]) win = o;
            if (id_hit(o, f_id, f_ext) && m_ctrl[o][1]) tset[o] = 1'b1;
        end
        if (win >= 0) pre_fresh = m_ctrl[win][4];
        pi = pend_idx();
        @(negedge clk);
        idle_inputs();
        if (f_en) begin
            rx_valid = 1'b1; rx_id = f_id; rx_ext = f_ext; rx_rtr = f_rtr;
            rx_dlc = f_dlc; rx_data = f_data;
        end
        if (w_en) begin
            hst_we = 1'b1; hst_obj = 4'(w_o); hst_field = 3'(w_f); hst_wdata = w_v;
        end
        tx_ack = a_en;
        if (w_en) mwr(w_o, w_f, w_v);
        if (a_en && pi >= 0) m_ctrl[pi][3] = 1'b0;
        if (f_en && !f_rtr && win >= 0) begin
            m_len[win]     = (f_dlc > 4'd8) ? 4'd8 : f_dlc;
            m_data[win]    = f_data;
            m_ctrl[win][5] = m_ctrl[win][5] | pre_fresh;
            m_ctrl[win][4] = 1'b1;
        end
        if (f_en && f_rtr)
            for (int o = 0; o < NOBJ; o++) if (tset[o]) m_ctrl[o][3] = 1'b1;
        @(negedge clk);
        idle_inputs();
        if (f_en) begin
            if (f_rtr) chk("R7 remote frame rx_hit", 64'(rx_hit), 64'd0);
            else begin
                chk("R4 rx_hit", 64'(rx_hit), 64'(win >= 0));
                chk("R4 rx_hit_idx", 64'(rx_hit_idx), 64'((win >= 0) ? win : 0));
            end
        end
    endtask

    task automatic wr(input int o, input int f, input logic [31:0] v);
        cycle(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, o, f, v, 1'b0);
    endtask

    task automatic frm(input logic [28:0] id, input logic ext, input logic rtr,
                       input logic [3:0] dlc, input logic [63:0] d);
        cycle(1'b1, id, ext, rtr, dlc, d, 1'b0, 0, 0, '0, 1'b0);
    endtask

    task automatic ack();
        cycle(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 0, 0, '0, 1'b1);
    endtask

    task automatic rd(input int o, input int f, output logic [31:0] v);
        @(negedge clk);
        idle_inputs();
        hst_obj = 4'(o); hst_field = 3'(f);
        #1 v = hst_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int o = 0; o < 16; o++) begin
            for (int f = 0; f < 5; f++) begin
                rd(o, f, v);
                if (o >= NOBJ) chk("R11 out-of-range read", 64'(v), 64'd0);
                else begin
                    case (f)
                        0: chk({tag, " ctrl"}, 64'(v), 64'(m_ctrl[o]));
                        1: chk({tag, " id"},   64'(v), 64'(m_id[o]));
                        2: chk({tag, " len"},  64'(v), 64'(m_len[o]));
                        3: chk({tag, " dlo"},  64'(v), 64'(m_data[o][31:0]));
                        default: chk({tag, " dhi"}, 64'(v), 64'(m_data[o][63:32]));
                    endcase
                end
            end
        end
        rd(3, 7, v);
        chk({tag, " mask"}, 64'(v), 64'(m_mask));
    endtask

    task automatic check_tx(input string tag);
        int pi;
        #1 pi = pend_idx();
        chk({tag, " tx_pend"}, 64'(tx_pend), 64'(pi >= 0));
        chk({tag, " tx_idx"},  64'(tx_idx),  64'((pi >= 0) ? pi : 0));
        chk({tag, " tx_id"},   64'(tx_id),   (pi >= 0) ? 64'(m_id[pi]) : 64'd0);
        chk({tag, " tx_ext"},  64'(tx_ext),  (pi >= 0) ? 64'(m_ctrl[pi][2]) : 64'd0);
        chk({tag, " tx_dlc"},  64'(tx_dlc),  (pi >= 0) ? 64'(m_len[pi]) : 64'd0);
        chk({tag, " tx_data"}, tx_data,      (pi >= 0) ? m_data[pi] : 64'd0);
    endtask

    initial begin
        logic [31:0] v;
        for (int o = 0; o < NOBJ; o++) begin
            m_ctrl[o] = '0; m_id[o] = '0; m_len[o] = '0; m_data[o] = '0;
        end
        m_mask = 29'h1FFF_FFFF;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 rx_hit after reset", 64'(rx_hit), 64'd0);
        chk("R1 rx_hit_idx after reset", 64'(rx_hit_idx), 64'd0);
        check_tx("R1");
        check_all("R1");

        // R2 / R11: write and read every field, including over-wide values
        for (int o = 0; o < 16; o++) begin
            wr(o, 1, 32'hFFFF_FFF0 ^ 32'(o));
            wr(o, 2, 32'hFFFF_FFF0 | 32'(o));
            wr(o, 3, 32'hA500_0000 | 32'(o));
            wr(o, 4, ~(32'hA500_0000 | 32'(o)));
            wr(o, 0, 32'hFFFF_FF00 | 32'((o * 5) & 63));
        end
        check_all("R2");
        check_tx("R2");
        for (int o = 0; o < NOBJ; o++) wr(o, 0, 32'h0);

        // R3 / R4: standard receive objects, ids repeat every 5 objects
        for (int o = 0; o < NOBJ; o++) begin
            wr(o, 1, 32'h100 + 32'(o % 5));
            wr(o, 0, (o == 0) ? 32'h0 : ((o == 1) ? 32'h3 : 32'h1));
        end
        for (int k = 0; k < 6; k++)
            frm(29'h100 + 29'(k), 1'b0, 1'b0, 4'd2, 64'h1111_0000_0000_0000 | 64'(k));
        // R3: upper id bits ignored for a standard frame
        frm(29'h1FFF_F800 | 29'h102, 1'b0, 1'b0, 4'd3, 64'hFEED_0000_0000_0102);
        // R3: extended objects
        wr(12, 1, 32'h0ABC_DE12); wr(12, 0, 32'h5);
        wr(13, 1, 32'h612);
        frm(29'h0ABC_DE12, 1'b1, 1'b0, 4'd8, 64'h0123_4567_89AB_CDEF);
        frm(29'h0ABC_DE13, 1'b1, 1'b0, 4'd8, 64'h0);
        frm(29'h0000_0612, 1'b1, 1'b0, 4'd1, 64'h77);
        frm(29'h0000_0612, 1'b0, 1'b0, 4'd1, 64'h78);
        // R3: acceptance mask ignoring the low 4 bits
        wr(0, 7, 32'h1FFF_FFF0);
        frm(29'h10F, 1'b0, 1'b0, 4'd4, 64'hCAFE_0000_0000_010F);
        wr(0, 7, 32'hFFFF_FFFF);
        check_all("R3");

        // R5 / R6: length clamp sweep on object 4
        wr(4, 0, 32'h1);
        for (int d = 0; d < 16; d++) begin
            frm(29'h104, 1'b0, 1'b0, 4'(d), {8{8'(d)}} ^ 64'h0123_4567_89AB_CDEF);
            rd(4, 2, v);
            chk("R5 stored length", 64'(v), 64'((d > 8) ? 8 : d));
            rd(4, 3, v);
            chk("R5 stored data", 64'(v), 64'(({8{8'(d)}} ^ 64'h0123_4567_89AB_CDEF) & 64'hFFFF_FFFF));
            rd(4, 0, v);
            chk("R6 fresh/lost", 64'(v), (d == 0) ? 64'h11 : 64'h31);
        end

        // R7 / R8 / R9: remote frames raise transmit requests
        wr(6, 1, 32'h222); wr(6, 0, 32'h3); wr(6, 2, 32'h5);
        wr(6, 3, 32'h1234_5678); wr(6, 4, 32'h9ABC_DEF0);
        wr(11, 1, 32'h222); wr(11, 0, 32'h3);
        wr(8, 1, 32'h222); wr(8, 0, 32'h1);
        check_tx("R8 none pending");
        frm(29'h222, 1'b0, 1'b1, 4'd0, 64'hDEAD);
        check_tx("R7 remote set");
        wr(14, 0, 32'hB);
        check_tx("R8 lowest pending");
        ack();
        check_tx("R9 after first ack");
        ack();
        check_tx("R9 after second ack");
        ack();
        check_tx("R9 after third ack");
        check_all("R7");

        // R10: host write and frame on the same object in one clock
        frm(29'h222, 1'b0, 1'b0, 4'd2, 64'h0202);
        cycle(1'b1, 29'h222, 1'b0, 1'b0, 4'd6, 64'h0606_0606,
              1'b1, 8, 0, 32'h1, 1'b0);
        rd(8, 0, v);
        chk("R10 ctrl after write+frame", 64'(v), 64'h31);
        wr(8, 0, 32'h1);
        cycle(1'b1, 29'h222, 1'b0, 1'b0, 4'd7, 64'hABCD_0707_0707_0707,
              1'b1, 8, 3, 32'h5555_5555, 1'b0);
        rd(8, 3, v);
        chk("R10 data after write+frame", 64'(v), 64'h0707_0707);
        // R10: remote set beats acknowledge on the same object
        frm(29'h222, 1'b0, 1'b1, 4'd0, 64'h0);
        check_tx("R10 pending before ack");
        cycle(1'b1, 29'h222, 1'b0, 1'b1, 4'd0, 64'h0, 1'b0, 0, 0, '0, 1'b1);
        check_tx("R10 ack with remote");
        check_all("R10");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule